// File: doc/BRIEF.md
# Spike Event Packet Composer

This block watches a stream of membrane-potential updates from a neuron simulation core. It records a spike event for a preselected neuron when that neuron's potential rises through a programmable threshold. Each event becomes one 32-bit word that holds the neuron number and the simulation time step. Events collect in a single packet buffer of one header section followed by a fixed number of data words.

A packet closes in one of two ways: the last data slot fills, or a flush request arrives while at least one event is stored. The packet then raises a ready flag. An upstream controller drains the packet one word per clock, starting with the header. Data slots that hold no event read back as all-ones. While a packet waits to be drained, new events are discarded and a sticky overflow flag records the loss.

Top module: `spike_pkt_composer`

## Requirements
- R1: After reset, `pkt_ready`, `overflow` and `rd_data` are 0. No neuron is selected. Every neuron's crossing state reads "at or below threshold". The first packet number is 0.
- R2: An update creates an event only when all of these hold: the neuron is selected, its signed potential is strictly greater than `threshold`, and its previous update since reset was at or below `threshold` (or it has had none). A potential equal to the threshold is not above it. Every in-range update refreshes the neuron's crossing state, whether or not the neuron is selected and whether or not the event is kept.
- R3: An event's data word carries the neuron ID in bits [31:TIME_W] and `sim_time` in bits [TIME_W-1:0]. Events are stored in arrival order.
- R4: A selection write with `sel_on`=1 selects a neuron. The write is ignored when the neuron is already selected or when MAX_SEL neurons are already selected. A write with `sel_on`=0 deselects the neuron. IDs at or above NEURONS are ignored on both the update and the selection paths. An update in the same cycle as a selection write sees the old selection.
- R5: When the event that fills the last of DATA_WORDS slots is stored, `pkt_ready` rises on the next clock without any flush.
- R6: A `flush` with at least one stored event, or with an event in the same cycle, closes the packet and `pkt_ready` rises on the next clock. An event in the flush cycle is included. A `flush` with no events has no effect. Data slots past the last event read 32'hFFFFFFFF.
- R7: Header word 0 is {PKT_TYPE[7:0], 8'h00, packet number zero-extended to 16 bits}. Word 1 holds the event count in its low bits, with the upper bits zero. Words 2 and 3 are zero.
- R8: While `pkt_ready` is high, `rd_data` shows the word at the read position, starting at header word 0. After the final word (index 3+DATA_WORDS) is read, `pkt_ready` falls on the next clock. The packet number then increases by one and wraps to 0 at 2^PNUM_W.
- R9: While `pkt_ready` is high, any event is discarded and never stored later. `overflow` rises on the next clock and stays high until reset. A `flush` in this state is ignored.
- R10: The read position advances by exactly one word in each cycle where `pkt_ready` and `rd_en` are both high, and holds otherwise. `rd_en` has no effect while `pkt_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Potential update valid |
| upd_id | input | ID_W | Neuron number of the update |
| upd_pot | input | POT_W | Signed membrane potential |
| sim_time | input | TIME_W | Current simulation time step |
| threshold | input | POT_W | Signed spike threshold |
| sel_wr | input | 1 | Selection write strobe |
| sel_id | input | ID_W | Neuron number to select or deselect |
| sel_on | input | 1 | 1 selects, 0 deselects |
| flush | input | 1 | Close the current packet early |
| rd_en | input | 1 | Consume the current output word |
| pkt_ready | output | 1 | A complete packet is waiting |
| rd_data | output | 32 | Current packet word |
| overflow | output | 1 | Sticky: an event was discarded |

## Verification
The bench builds the block with 40 neurons, 6 data slots, a selection cap of 4 and a 3-bit packet number. These values keep the field layout at 11+21 bits. With this configuration, a full packet, the selection cap and packet-number wrap-around are each reached in a few dozen cycles. The bench also exercises several other corners: an update exactly at the threshold, a selected neuron whose stored state is already above threshold, flush together with an event, an empty flush, and events discarded during a read-out.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    BUF_FILL  = 1'b0,
    BUF_READY = 1'b1
  } buf_state_e;
endpackage

// File: rtl/spk_detect.sv
module spk_detect #(
  parameter int NEURONS = 1600,
  parameter int ID_W    = 11,
  parameter int POT_W   = 16,
  parameter int MAX_SEL = 124
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_valid,
  input  logic [ID_W-1:0]         upd_id,
  input  logic signed [POT_W-1:0] upd_pot,
  input  logic signed [POT_W-1:0] threshold,
  input  logic                    sel_wr,
  input  logic [ID_W-1:0]         sel_id,
  input  logic                    sel_on,
  output logic                    fire
);
  localparam int IX_W = (NEURONS > 1) ? $clog2(NEURONS) : 1;
  localparam int SC_W = $clog2(MAX_SEL + 1);

  logic [NEURONS-1:0] above_q, above_d;
  logic [NEURONS-1:0] sel_q, sel_d;
  logic [SC_W-1:0]    nsel_q, nsel_d;
  logic               upd_ok, sel_ok, over;
  logic [IX_W-1:0]    ux, sx;

  assign ux     = upd_id[IX_W-1:0];
  assign sx     = sel_id[IX_W-1:0];
  assign upd_ok = upd_valid && (32'(upd_id) < 32'(NEURONS));
  assign sel_ok = sel_wr && (32'(sel_id) < 32'(NEURONS));
  assign over   = upd_pot > threshold;
  assign fire   = upd_ok && sel_q[ux] && !above_q[ux] && over;

  always_comb begin
    above_d = above_q;
    sel_d   = sel_q;
    nsel_d  = nsel_q;
    if (upd_ok) above_d[ux] = over;
    if (sel_ok) begin
      if (sel_on && !sel_q[sx] && (nsel_q < SC_W'(MAX_SEL))) begin
        sel_d[sx] = 1'b1;
        nsel_d    = nsel_q + SC_W'(1);
      end else if (!sel_on && sel_q[sx]) begin
        sel_d[sx] = 1'b0;
        nsel_d    = nsel_q - SC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= '0;
      sel_q   <= '0;
      nsel_q  <= '0;
    end else begin
      if (upd_ok) above_q <= above_d;
      if (sel_ok) begin
        sel_q  <= sel_d;
        nsel_q <= nsel_d;
      end
    end
  end
endmodule

// File: rtl/spk_buffer.sv
module spk_buffer
  import spk_pkg::*;
#(
  parameter int          DATA_WORDS = 124,
  parameter int          PNUM_W     = 16,
  parameter logic [7:0]  PKT_TYPE   = 8'h01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_valid,
  input  word_t ev_word,
  input  logic  flush,
  input  logic  rd_en,
  output logic  pkt_ready,
  output word_t rd_data,
  output logic  overflow
);
  localparam int TOTAL = HDR_WORDS + DATA_WORDS;
  localparam int PTR_W = $clog2(TOTAL);
  localparam int CNT_W = $clog2(DATA_WORDS + 1);
  localparam int IDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;

  word_t           mem_q [DATA_WORDS];
  buf_state_e      st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, dptr;
  logic [PNUM_W-1:0] pnum_q, pnum_d;
  logic            ovf_q, ovf_d;
  logic            filling, accept, close, rd_go, rd_end, st_en;

  assign filling = (st_q == BUF_FILL);
  assign accept  = filling && ev_valid;
  assign close   = (accept && (cnt_q == CNT_W'(DATA_WORDS - 1))) ||
                   (filling && flush && ((cnt_q != '0) || ev_valid));
  assign rd_go   = (st_q == BUF_READY) && rd_en;
  assign rd_end  = rd_go && (ptr_q == PTR_W'(TOTAL - 1));
  assign st_en   = close || rd_end;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    pnum_d = pnum_q;
    ovf_d  = ovf_q || ((st_q == BUF_READY) && ev_valid);
    if (accept) cnt_d = cnt_q + CNT_W'(1);
    if (close)  st_d  = BUF_READY;
    if (rd_go)  ptr_d = ptr_q + PTR_W'(1);
    if (rd_end) begin
      st_d   = BUF_FILL;
      cnt_d  = '0;
      ptr_d  = '0;
      pnum_d = pnum_q + PNUM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[cnt_q[IDX_W-1:0]] <= ev_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUF_FILL;
      cnt_q  <= '0;
      ptr_q  <= '0;
      pnum_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      if (accept || rd_end) cnt_q <= cnt_d;
      if (rd_go) ptr_q <= ptr_d;
      if (rd_end) pnum_q <= pnum_d;
      ovf_q <= ovf_d;
    end
  end

  assign dptr = ptr_q - PTR_W'(HDR_WORDS);

  always_comb begin
    rd_data = '0;
    if (st_q == BUF_READY) begin
      if (32'(ptr_q) == 0)      rd_data = {PKT_TYPE, 8'h00, 16'(pnum_q)};
      else if (32'(ptr_q) == 1) rd_data = WORD_W'(cnt_q);
      else if (32'(ptr_q) < HDR_WORDS) rd_data = '0;
      else if (32'(dptr) < 32'(cnt_q)) rd_data = mem_q[dptr[IDX_W-1:0]];
      else rd_data = '1;
    end
  end

  assign pkt_ready = (st_q == BUF_READY);
  assign overflow  = ovf_q;
endmodule

// File: rtl/spike_pkt_composer.sv
module spike_pkt_composer
  import spk_pkg::*;
#(
  parameter int         NEURONS    = 1600,
  parameter int         ID_W       = 11,
  parameter int         TIME_W     = 21,
  parameter int         POT_W      = 16,
  parameter int         DATA_WORDS = 124,
  parameter int         MAX_SEL    = 124,
  parameter int         PNUM_W     = 16,
  parameter logic [7:0] PKT_TYPE   = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_valid,
  input  logic [ID_W-1:0]         upd_id,
  input  logic signed [POT_W-1:0] upd_pot,
  input  logic [TIME_W-1:0]       sim_time,
  input  logic signed [POT_W-1:0] threshold,
  input  logic                    sel_wr,
  input  logic [ID_W-1:0]         sel_id,
  input  logic                    sel_on,
  input  logic                    flush,
  input  logic                    rd_en,
  output logic                    pkt_ready,
  output logic [31:0]             rd_data,
  output logic                    overflow
);
  logic  ev_fire;
  word_t ev_word;

  assign ev_word = {upd_id, sim_time};

  spk_detect #(
    .NEURONS(NEURONS), .ID_W(ID_W), .POT_W(POT_W), .MAX_SEL(MAX_SEL)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_id(upd_id),
    .upd_pot(upd_pot), .threshold(threshold), .sel_wr(sel_wr),
    .sel_id(sel_id), .sel_on(sel_on), .fire(ev_fire)
  );

  spk_buffer #(
    .DATA_WORDS(DATA_WORDS), .PNUM_W(PNUM_W), .PKT_TYPE(PKT_TYPE)
  ) u_buffer (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_fire), .ev_word(ev_word),
    .flush(flush), .rd_en(rd_en), .pkt_ready(pkt_ready),
    .rd_data(rd_data), .overflow(overflow)
  );
endmodule

// File: rtl/spk_chk.sv
module spk_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic rd_en,
  input logic pkt_ready,
  input logic overflow,
  input logic ev_fire
);
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && ev_fire) |=> overflow);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !rd_en) |=> pkt_ready);

  // R8
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_ready) |-> $past(rd_en));

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> $past(flush || ev_fire));
endmodule

bind spike_pkt_composer spk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rd_en(rd_en),
  .pkt_ready(pkt_ready), .overflow(overflow), .ev_fire(ev_fire)
);

// File: tb/spike_pkt_composer_test.sv
module spike_pkt_composer_test;
  localparam int         NEU  = 40;
  localparam int         IDW  = 11;
  localparam int         TW   = 21;
  localparam int         PW   = 16;
  localparam int         DW   = 6;
  localparam int         MAXS = 4;
  localparam int         PNW  = 3;
  localparam logic [7:0] TYP  = 8'h3C;

  logic clk = 1'b0;
  logic rst_n;
  logic upd_valid, sel_wr, sel_on, flush, rd_en;
  logic [IDW-1:0] upd_id, sel_id;
  logic signed [PW-1:0] upd_pot, threshold;
  logic [TW-1:0] sim_time;
  logic pkt_ready, overflow;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spike_pkt_composer #(
    .NEURONS(NEU), .ID_W(IDW), .TIME_W(TW), .POT_W(PW), .DATA_WORDS(DW),
    .MAX_SEL(MAXS), .PNUM_W(PNW), .PKT_TYPE(TYP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_id(upd_id),
    .upd_pot(upd_pot), .sim_time(sim_time), .threshold(threshold),
    .sel_wr(sel_wr), .sel_id(sel_id), .sel_on(sel_on), .flush(flush),
    .rd_en(rd_en), .pkt_ready(pkt_ready), .rd_data(rd_data),
    .overflow(overflow)
  );

  // Behavioural reference model
  bit  mprev [NEU];
  bit  msel  [NEU];
  int  mselcnt, mptr, mpnum;
  bit  mready, movf;
  logic [31:0] mq [$];

  always @(posedge clk or negedge rst_n) begin
    bit ev, over;
    if (!rst_n) begin
      for (int i = 0; i < NEU; i++) begin mprev[i] = 0; msel[i] = 0; end
      mselcnt = 0; mptr = 0; mpnum = 0; mready = 0; movf = 0;
      mq.delete();
    end else begin
      ev = 0;
      if (upd_valid && int'(upd_id) < NEU) begin
        over = upd_pot > threshold;
        if (msel[upd_id] && !mprev[upd_id] && over) ev = 1;
        mprev[upd_id] = over;
      end
      if (sel_wr && int'(sel_id) < NEU) begin
        if (sel_on && !msel[sel_id] && mselcnt < MAXS) begin
          msel[sel_id] = 1; mselcnt++;
        end else if (!sel_on && msel[sel_id]) begin
          msel[sel_id] = 0; mselcnt--;
        end
      end
      if (!mready) begin
        if (ev) mq.push_back({upd_id, sim_time});
        if (mq.size() == DW || (flush && mq.size() > 0)) begin
          mready = 1; mptr = 0;
        end
      end else begin
        if (ev) movf = 1;
        if (rd_en) begin
          if (mptr == DW + 3) begin
            mready = 0; mptr = 0; mq.delete();
            mpnum = (mpnum + 1) % (1 << PNW);
          end else mptr++;
        end
      end
    end
  end

  function automatic logic [31:0] exp_word();
    if (!mready) return 32'h0;
    if (mptr == 0) return {TYP, 8'h00, 16'(mpnum)};
    if (mptr == 1) return 32'(mq.size());
    if (mptr < 4) return 32'h0;
    if (mptr - 4 < mq.size()) return mq[mptr - 4];
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 pkt_ready vs model", 32'(pkt_ready), 32'(mready));
      check("R9 overflow vs model", 32'(overflow), 32'(movf));
      check("R7 rd_data vs model", rd_data, exp_word());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic upd(int id, int pot, int t, bit fl = 0);
    upd_valid = 1; upd_id = IDW'(id); upd_pot = PW'(pot);
    sim_time = TW'(t); flush = fl;
    tick();
    upd_valid = 0; flush = 0;
  endtask

  task automatic sel(int id, bit on);
    sel_wr = 1; sel_id = IDW'(id); sel_on = on;
    tick();
    sel_wr = 0;
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0;
  endtask

  task automatic read_all();
    rd_en = 1;
    repeat (DW + 4) tick();
    rd_en = 0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; upd_valid = 0; sel_wr = 0; sel_on = 0; flush = 0; rd_en = 0;
    upd_id = '0; sel_id = '0; upd_pot = '0; sim_time = '0;
    threshold = 16'sd100;
    repeat (3) tick();
    check("R1 reset pkt_ready", 32'(pkt_ready), 0);
    check("R1 reset overflow", 32'(overflow), 0);
    check("R1 reset rd_data", rd_data, 0);
    rst_n = 1;
    tick();

    // R4: cap at MAXS, out-of-range id ignored
    sel(1, 1); sel(2, 1); sel(3, 1); sel(5, 1);
    sel(7, 1);            // ignored, cap reached
    sel(45, 1);           // out of range
    upd(7, 200, 2);       // not selected: no event
    upd(45, 200, 2);      // out of range: no event
    sel(5, 0); sel(7, 1);

    // R2: crossing rules
    upd(1, 100, 1);       // equal: no event
    upd(1, 101, 5);       // event (1,5)
    upd(7, 200, 8);       // state already above: no event
    upd(7, 0, 6);
    upd(7, 200, 9);       // event (7,9)
    upd(1, 150, 10);
    upd(5, 200, 11);      // deselected
    upd(2, -5, 11);
    upd(1, 50, 11);
    upd(1, 120, 12);      // event (1,12)
    check("R6 no ready before flush", 32'(pkt_ready), 0);
    do_flush();
    check("R6 ready after flush", 32'(pkt_ready), 1);
    check("R7 header word0", rd_data, 32'h3C00_0000);
    rd_en = 1; tick();
    check("R7 event count word (R2 R4: three events)", rd_data, 32'd3);
    tick(); check("R7 header word2", rd_data, 0);
    tick(); check("R7 header word3", rd_data, 0);
    tick(); check("R3 data word neuron1 t5", rd_data, 32'h0020_0005);
    tick(); check("R3 data word neuron7 t9", rd_data, 32'h00E0_0009);
    tick(); check("R3 data word neuron1 t12", rd_data, 32'h0020_000C);
    tick(); check("R6 padding word", rd_data, 32'hFFFF_FFFF);
    rd_en = 0; tick();
    check("R10 hold without rd_en", rd_data, 32'hFFFF_FFFF);
    rd_en = 1; tick(); tick(); tick();
    rd_en = 0;
    check("R8 ready falls after last word", 32'(pkt_ready), 0);
    rd_en = 1; tick(); rd_en = 0;   // R10: rd_en while idle ignored
    do_flush();
    check("R6 empty flush ignored", 32'(pkt_ready), 0);

    // R5: full packet closes by itself
    for (int k = 0; k < DW; k++) begin
      int n;
      n = (k % 4 == 3) ? 7 : (k % 4) + 1;
      upd(n, 0, 19);
      if (k == DW - 1) check("R5 not ready before last event", 32'(pkt_ready), 0);
      upd(n, 150, 20 + k);
    end
    check("R5 ready after last slot", 32'(pkt_ready), 1);

    // R9: drop while waiting
    upd(2, 0, 30);
    upd(2, 150, 31);
    check("R9 overflow set", 32'(overflow), 1);
    do_flush();
    check("R7 header packet number 1", rd_data, 32'h3C00_0001);
    read_all();
    do_flush();
    check("R9 dropped event not kept", 32'(pkt_ready), 0);
    check("R9 overflow sticky", 32'(overflow), 1);

    // R8 wrap and R6 event with flush
    for (int p = 2; p < 9; p++) begin
      upd(3, 0, 40 + p);
      upd(3, 150, 50 + p, 1);
      check("R6 flush with event closes", 32'(pkt_ready), 1);
      if (p == 8) check("R8 packet number wraps", rd_data, 32'h3C00_0000);
      rd_en = 1; tick(); rd_en = 0;
      check("R6 flush-cycle event counted", rd_data, 32'd1);
      rd_en = 1; repeat (DW + 3) tick(); rd_en = 0;
    end

    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule